// File: doc/BRIEF.md
# UART with Shared Completion Interrupt

This block is an asynchronous serial transceiver behind a four-location register interface. Software programs a mode register (transmit enable, receive enable, parity enable, odd parity, error-interrupt mask), writes bytes to send and reads bytes received. Frames carry one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A free-running baud tick input at sixteen times the bit rate paces both directions. No baud generator sits inside the block.

Finishing a transmitted frame and finishing a received frame both raise one shared interrupt line. Each event has its own sticky flag, so the service routine reads the flag register to learn which event occurred and writes a one to clear that flag. Received bytes are always stored, even with a parity, framing or overrun error. The mask bit decides only whether such a frame also raises the receive flag.

Top module: `uart_shared_irq`

## Requirements
- R1: After reset, txd is high, irq is low, and all four addresses read 0. The addresses are 0 mode, 1 data, 2 flags and 3 status.
- R2: Writing address 1 while mode bit 7 is 1 and no frame is in progress transmits a frame. The frame is a low start bit, the eight data bits LSB first, then a parity bit when mode bit 2 is 1, then a high stop bit. The parity bit is the XOR of the data bits, inverted when mode bit 3 is 1. Each bit lasts OVS baud ticks. While mode bit 7 is 0, a write to address 1 leaves txd high and sets no flag.
- R3: While mode bit 6 is 0, the receiver stays idle. A frame on rxd sets no flag and stores nothing.
- R4: The receiver starts on a low rxd at a baud tick and samples each bit at the middle tick of its OVS-tick period. If rxd is high again at mid start bit, the start is dropped and nothing is received.
- R5: Every completed frame is moved into the receive buffer read at address 1, including frames with errors. The status register at address 3 reports four bits: bit 0 is a parity mismatch, bit 1 is a stop bit sampled low, bit 2 is overrun (a frame completed while the previous byte was unread), and bit 3 is unread data. After a low stop bit, the receiver waits for rxd to go high before it accepts a new start.
- R6: A completed frame sets flag bit 1, except when mode bit 1 is 1 and the frame has a parity, framing or overrun error. In that case no flag is set.
- R7: Flag bit 0 (transmit done) and flag bit 1 (receive done) are cleared only by writing a 1 to that bit at address 2. Hardware never clears them.
- R8: irq is high whenever either flag is set. It stays high until both flags are cleared.
- R9: A write to address 1 during a frame in progress is ignored. Flag bit 0 sets only once the whole stop bit period has gone out, and not before.
- R10: A read of address 1 clears status bits 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at OVS times the bit rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects at address 1) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Shared completion interrupt |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The in-module assertions run every cycle. They check that a transmit frame starts only from an enabled data write, and that a write during a frame leaves the shift register alone. They also check that the receiver stays idle while disabled, that every completion marks data unread, that a rising receive flag matches the mask rule, and that no flag falls without a clearing write. Several behaviours need whole frames and are shown only by the bench scenarios: the bit order and parity on txd, the timing of the done flag, sampling at mid-bit with rejection of a short start glitch, storage of errored bytes with the right status bits, overrun, and the OR behaviour of irq.

// File: rtl/uart_shared_irq.sv
module uart_shared_irq #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       txd,
  input  logic       rxd
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] CNT_MAX = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_MID = CW'(OVS / 2 - 1);
  localparam logic [1:0] A_MODE = 2'd0, A_DATA = 2'd1, A_FLAG = 2'd2, A_STAT = 2'd3;

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  logic [7:0] mode;
  wire tx_en    = mode[7];
  wire rx_en    = mode[6];
  wire par_en   = mode[2];
  wire par_odd  = mode[3];
  wire err_mask = mode[1];

  wire mode_wr = wr_en && addr == A_MODE;
  wire tx_wr   = wr_en && addr == A_DATA;
  wire flag_wr = wr_en && addr == A_FLAG;
  wire rx_rd   = rd_en && addr == A_DATA;

  always_ff @(posedge clk)
    if (!rst_n) mode <= '0;
    else if (mode_wr) mode <= wdata;

  // transmitter
  logic          tx_busy, tx_flag;
  logic [10:0]   tx_sh;
  logic [3:0]    tx_bit, tx_last;
  logic [CW-1:0] tx_cnt;

  wire tx_start = tx_wr && tx_en && !tx_busy;
  wire tx_end   = tx_busy && baud_tick && tx_cnt == CNT_MAX && tx_bit == tx_last;

  always_ff @(posedge clk)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_bit  <= '0;
      tx_cnt  <= '0;
      tx_last <= 4'd9;
    end else if (tx_start) begin
      tx_busy <= 1'b1;
      tx_sh   <= par_en ? {1'b1, par_of(wdata, par_odd), wdata, 1'b0} : {2'b11, wdata, 1'b0};
      tx_bit  <= '0;
      tx_cnt  <= '0;
      tx_last <= par_en ? 4'd10 : 4'd9;
    end else if (tx_busy && baud_tick) begin
      if (tx_cnt == CNT_MAX) begin
        tx_cnt <= '0;
        tx_sh  <= {1'b1, tx_sh[10:1]};
        if (tx_bit == tx_last) tx_busy <= 1'b0;
        else tx_bit <= tx_bit + 4'd1;
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) tx_flag <= 1'b0;
    else if (tx_end) tx_flag <= 1'b1;
    else if (flag_wr && wdata[0]) tx_flag <= 1'b0;

  // receiver
  logic [1:0]    rx_sync;
  logic          rx_act, rx_arm, rx_par_en, rx_par_odd, rx_pbit;
  logic [3:0]    rx_bit, rx_last;
  logic [CW-1:0] rx_cnt;
  logic [7:0]    rx_sh, rx_buf;
  logic          rx_full, fe, pe, oe, rx_flag;

  wire rxs    = rx_sync[1];
  wire rx_mid = rx_act && baud_tick && rx_cnt == CNT_MID;
  wire rx_cmp = rx_mid && rx_bit == rx_last;
  wire fe_now = !rxs;
  wire pe_now = rx_par_en && (rx_pbit != par_of(rx_sh, rx_par_odd));
  wire rx_err_now = fe_now || pe_now || rx_full;

  always_ff @(posedge clk)
    if (!rst_n) rx_sync <= 2'b11;
    else rx_sync <= {rx_sync[0], rxd};

  always_ff @(posedge clk)
    if (!rst_n) begin
      rx_act     <= 1'b0;
      rx_bit     <= '0;
      rx_cnt     <= '0;
      rx_last    <= 4'd9;
      rx_par_en  <= 1'b0;
      rx_par_odd <= 1'b0;
    end else if (!rx_en) begin
      rx_act <= 1'b0;
    end else if (!rx_act) begin
      if (baud_tick && !rxs && rx_arm) begin
        rx_act     <= 1'b1;
        rx_bit     <= '0;
        rx_cnt     <= '0;
        rx_par_en  <= par_en;
        rx_par_odd <= par_odd;
        rx_last    <= par_en ? 4'd10 : 4'd9;
      end
    end else if (baud_tick) begin
      if (rx_cnt == CNT_MID && (rx_bit == rx_last || (rx_bit == 4'd0 && rxs)))
        rx_act <= 1'b0;
      if (rx_cnt == CNT_MAX) begin
        rx_cnt <= '0;
        rx_bit <= rx_bit + 4'd1;
      end else begin
        rx_cnt <= rx_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk)
    if (!rst_n) rx_arm <= 1'b1;
    else if (rx_cmp && !rxs) rx_arm <= 1'b0;
    else if (rxs) rx_arm <= 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      rx_sh   <= '0;
      rx_pbit <= 1'b0;
    end else if (rx_mid) begin
      if (rx_bit >= 4'd1 && rx_bit <= 4'd8) rx_sh <= {rxs, rx_sh[7:1]};
      if (rx_bit == 4'd9 && rx_par_en) rx_pbit <= rxs;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      fe      <= 1'b0;
      pe      <= 1'b0;
      oe      <= 1'b0;
    end else if (rx_cmp) begin
      rx_buf  <= rx_sh;
      rx_full <= 1'b1;
      fe      <= fe_now;
      pe      <= pe_now;
      oe      <= rx_full;
    end else if (rx_rd) begin
      rx_full <= 1'b0;
      fe      <= 1'b0;
      pe      <= 1'b0;
      oe      <= 1'b0;
    end

  always_ff @(posedge clk)
    if (!rst_n) rx_flag <= 1'b0;
    else if (rx_cmp && !(rx_err_now && err_mask)) rx_flag <= 1'b1;
    else if (flag_wr && wdata[1]) rx_flag <= 1'b0;

  assign irq = tx_flag | rx_flag;

  always_comb
    case (addr)
      A_MODE:  rdata = mode;
      A_DATA:  rdata = rx_buf;
      A_FLAG:  rdata = {6'b0, rx_flag, tx_flag};
      A_STAT:  rdata = {4'b0, rx_full, oe, fe, pe};
      default: rdata = '0;
    endcase

  assert_tx_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_wr && tx_en));
  assert_tx_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_wr && !baud_tick) |=> $stable(tx_sh));
  assert_rx_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_act);
  assert_rx_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cmp |=> rx_full);
  assert_rx_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> ($past(rx_cmp) && !($past(err_mask) && $past(rx_err_now))));
  assert_tx_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_flag) |-> $past(flag_wr && wdata[0]));
  assert_rx_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_flag) |-> $past(flag_wr && wdata[1]));
endmodule

// File: tb/uart_shared_irq_tb.sv
module uart_shared_irq_tb_top;
  localparam int OVS = 16;
  localparam int TDIV = 2;
  localparam int BITCLK = OVS * TDIV;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, txd;
  int n_chk = 0, n_fail = 0;

  uart_shared_irq #(.OVS(OVS)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .txd(txd), .rxd(rxd));

  always #2 clk = ~clk;

  int tcnt = 0;
  always @(negedge clk) begin
    tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == TDIV - 1);
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic logic [10:0] frame(input logic [7:0] d, input logic pen, input logic odd);
    return pen ? {1'b1, (^d) ^ odd, d, 1'b0} : {2'b11, d, 1'b0};
  endfunction

  task automatic send_rx(input logic [7:0] d, input logic pen, input logic odd,
                         input logic bad_par, input logic bad_stop);
    logic [10:0] f = frame(d, pen, odd);
    int nb = pen ? 11 : 10;
    if (pen && bad_par) f[9] = ~f[9];
    if (bad_stop) f[nb-1] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (BITCLK - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
  endtask

  task automatic cap_tx(input int nb, output logic [10:0] got);
    int w = 0;
    got = '1;
    while (txd !== 1'b0 && w < 400) begin @(negedge clk); w++; end
    repeat (BITCLK / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      got[i] = txd;
      if (i < nb - 1) repeat (BITCLK) @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, d, d2;
    logic [10:0] got;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      check("R1", "register after reset", v, 0);
    end
    check("R1", "txd idle", txd, 1);
    check("R1", "irq idle", irq, 0);

    // R2 transmit frames, random data and parity
    for (int k = 0; k < 5; k++) begin
      logic pen = 1'($urandom % 2), odd = 1'($urandom % 2);
      d = 8'($urandom);
      wr(2'd0, 8'h80 | {4'b0, odd, pen, 2'b0});
      wr(2'd1, d);
      cap_tx(pen ? 11 : 10, got);
      check("R2", "tx frame bits", got, frame(d, pen, odd) | (pen ? 11'h0 : 11'h400));
      peek(2'd2, v);
      check("R9", "no done flag at mid stop", v[0], 0);
      repeat (BITCLK) @(negedge clk);
      peek(2'd2, v);
      check("R9", "done flag after stop", v[0], 1);
      check("R8", "irq with tx flag", irq, 1);
      wr(2'd2, 8'h01);
      check("R8", "irq after clear", irq, 0);
    end

    // R2 transmit disabled
    begin
      int lows = 0;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h5a);
      repeat (12 * BITCLK) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      check("R2", "txd low cycles while disabled", lows, 0);
      peek(2'd2, v);
      check("R2", "no flag while disabled", v, 0);
    end

    // R9 write during frame ignored
    begin
      int lows = 0;
      wr(2'd0, 8'h80);
      wr(2'd1, 8'hc3);
      fork
        cap_tx(10, got);
        begin repeat (3 * BITCLK) @(negedge clk); wr(2'd1, 8'h3c); end
      join
      check("R9", "frame unchanged by busy write", got, frame(8'hc3, 1'b0, 1'b0));
      repeat (BITCLK) @(negedge clk);
      repeat (4 * BITCLK) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      check("R9", "no second frame", lows, 0);
      wr(2'd2, 8'h01);
    end

    // R5 R6 R10 receive random frames with injected errors
    for (int k = 0; k < 8; k++) begin
      logic pen = 1'($urandom % 2), odd = 1'($urandom % 2), mask = 1'($urandom % 2);
      int et = int'($urandom % 4);
      logic bp = pen && (et == 1), bs = (et == 2);
      logic err = bp || bs;
      d = 8'($urandom);
      wr(2'd0, 8'h40 | {4'b0, odd, pen, mask, 1'b0});
      wr(2'd2, 8'h03);
      send_rx(d, pen, odd, bp, bs);
      peek(2'd2, v);
      check("R6", "rx flag vs mask", v[1], !(err && mask));
      peek(2'd3, v);
      check("R5", "rx status", v, {4'b1000 | {2'b0, bs, bp}});
      rd(2'd1, v);
      check("R5", "rx data", v, d);
      peek(2'd3, v);
      check("R10", "status after read", v, 0);
    end

    // R5 R6 overrun, masked
    wr(2'd0, 8'h42);
    d = 8'($urandom); d2 = 8'($urandom);
    send_rx(d, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(2'd2, 8'h03);
    send_rx(d2, 1'b0, 1'b0, 1'b0, 1'b0);
    peek(2'd3, v);
    check("R5", "overrun status", v, 8'h0c);
    peek(2'd2, v);
    check("R6", "masked overrun no flag", v, 0);
    rd(2'd1, v);
    check("R5", "overrun keeps newest", v, d2);

    // R3 receive disabled
    wr(2'd0, 8'h00);
    send_rx(8'ha5, 1'b0, 1'b0, 1'b0, 1'b0);
    peek(2'd2, v);
    check("R3", "no flag while rx off", v, 0);
    peek(2'd3, v);
    check("R3", "no data while rx off", v, 0);

    // R4 short start glitch
    wr(2'd0, 8'h40);
    @(negedge clk); rxd = 1'b0;
    repeat (2 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BITCLK) @(negedge clk);
    peek(2'd2, v);
    check("R4", "glitch gives no flag", v, 0);
    peek(2'd3, v);
    check("R4", "glitch gives no data", v, 0);

    // R7 R8 both flags, sticky, separate clears
    wr(2'd0, 8'hc0);
    wr(2'd1, 8'h77);
    repeat (12 * BITCLK) @(negedge clk);
    send_rx(8'h19, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (10 * BITCLK) @(negedge clk);
    peek(2'd2, v);
    check("R7", "both flags held", v, 8'h03);
    wr(2'd2, 8'h01);
    peek(2'd2, v);
    check("R7", "only tx flag cleared", v, 8'h02);
    check("R8", "irq with rx flag only", irq, 1);
    wr(2'd2, 8'h02);
    check("R8", "irq after both cleared", irq, 0);
    rd(2'd1, v);
    check("R5", "rx data in shared test", v, 8'h19);

    summary();
    $finish;
  end
endmodule